// File: doc/BRIEF.md
# CD Table-of-Contents Response Generator

This block produces the reply bytes for a table-of-contents request about a disc with a single data track. A one-cycle start pulse captures the request: the disc size in sectors, the wanted format (basic listing, session summary or raw listing), an address-style select (sector number or minute/second/frame) and the first track the caller wants. The block then emits the reply one byte per clock, with a valid flag and a flag on the final byte. A request it cannot honour raises an error pulse and produces no bytes.

Minute/second/frame addresses come from a small converter. It adds the 150-frame lead-in to the sector number and divides by 75 and then by 60, using two bit-serial dividers. When an address of that form is needed, the stream waits for the conversion to finish. Inputs are captured at the accepted start, so the caller may change them while the reply is being sent.

Top module: `toc_resp_gen`

## Requirements
- R1: While reset is applied and after it is released, with no start, `valid_o`, `last_o` and `err_o` are 0.
- R2: A minute/second/frame address of sector count L is the four bytes 0x00, M, S, F, where T = L + 150, F = T mod 75, S = (T / 75) mod 60 and M = T / 4500. M saturates at 0xFF when that quotient exceeds 255.
- R3: Every reply starts with a 16-bit big-endian length equal to the reply length minus 2, followed by the bytes 0x01 and 0x01.
- R4: Format 0 with start track 0 or 1 is 20 bytes. Bytes 4..11 are the track-1 entry 0x00, 0x14, 0x01, 0x00 followed by the address of sector 0: 00 00 02 00 in minute/second/frame style, 00 00 00 00 in sector style.
- R5: In format 0 the last 8 bytes are the lead-out entry 0x00, 0x16, 0xAA, 0x00 followed by the address of the sector count: the R2 form, or the count as a 4-byte big-endian number. With start track 0xAA the reply is 12 bytes and holds only the lead-out entry.
- R6: Format 0 with a start track above 1 other than 0xAA is rejected.
- R7: Format 1 is 12 bytes: 00 0A 01 01 followed by eight zero bytes, in either address style.
- R8: Format 2 is 48 bytes: the header, then four 11-byte records. Each record is 0x01, 0x14, 0x00, a point code, three zero bytes and a 4-byte tail. The point codes come in the order 0xA0, 0xA1, 0xA2, 0x01. The tails of 0xA0 and 0xA1 are 00 01 00 00. The tail of 0xA2 is the lead-out address as in R5. The tail of point 0x01 is the sector-0 address as in R4.
- R9: A format code above 2 (the format input is 4 bits wide) is rejected.
- R10: A reply is an unbroken run of valid cycles, one byte per cycle. `last_o` is high on the final byte only, and `valid_o` is low in the cycle after it.
- R11: In sector style and in format 1, the first byte is valid in the cycle after the start is accepted. Otherwise bytes begin only after the address conversion ends.
- R12: A start while a reply is in progress is ignored. Changing the inputs after an accepted start does not alter the reply.
- R13: A rejection drives `err_o` high for the one cycle after the start and emits no valid byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| sectors_i | input | SECW | Disc size in sectors |
| msf_i | input | 1 | 1 selects minute/second/frame addresses |
| fmt_i | input | 4 | Requested format code |
| trk_i | input | 8 | First track requested |
| data_o | output | 8 | Reply byte |
| valid_o | output | 1 | `data_o` holds a reply byte |
| last_o | output | 1 | Final byte of the reply |
| err_o | output | 1 | Request rejected |

## Verification
The stream assertions assume that a start arrives only while the block is idle, or is ignored when it does not. They also assume that the inputs are sampled only at an accepted start. The bench keeps `start_i` to a single cycle, changes every input once the start is taken, and raises a start in the middle of one reply. The divider's remainder bound holds for any dividend, so the sweep spans the full sector range: zero, 74 and 75 frame edges, the exact one-minute point, and the largest count, whose minutes saturate. The sweep covers every format, both address styles, and start tracks on either side of each rejection boundary.

// File: rtl/toc_pkg.sv
`timescale 1ns/1ps
package toc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_SEND = 2'd2
  } gen_state_e;

  localparam int unsigned LEADIN_FRAMES = 150;
  localparam int unsigned FRM_PER_SEC   = 75;
  localparam int unsigned SEC_PER_MIN   = 60;

  // address of sector 0 once the lead-in is added
  localparam logic [7:0] ZERO_FRM = 8'(LEADIN_FRAMES % FRM_PER_SEC);
  localparam logic [7:0] ZERO_SEC = 8'((LEADIN_FRAMES / FRM_PER_SEC) % SEC_PER_MIN);
  localparam logic [7:0] ZERO_MIN = 8'((LEADIN_FRAMES / FRM_PER_SEC) / SEC_PER_MIN);

  localparam logic [7:0] CTRL_DATA  = 8'h14;
  localparam logic [7:0] CTRL_LOUT  = 8'h16;
  localparam logic [7:0] TRK_LOUT   = 8'hAA;
  localparam logic [7:0] PT_FIRST   = 8'hA0;
  localparam logic [7:0] PT_LAST    = 8'hA1;
  localparam logic [7:0] PT_LOUT    = 8'hA2;
  localparam logic [7:0] PT_TRK1    = 8'h01;

  localparam int unsigned HDR_BYTES   = 4;
  localparam int unsigned ENTRY_BYTES = 8;
  localparam int unsigned DESC_BYTES  = 11;
  localparam int unsigned NUM_DESC    = 4;
  localparam int unsigned SESS_BYTES  = 12;

  function automatic logic [5:0] resp_len(input logic [1:0] f, input logic with_trk);
    logic [5:0] n;
    case (f)
      2'd0:    n = with_trk ? 6'(HDR_BYTES + 2*ENTRY_BYTES) : 6'(HDR_BYTES + ENTRY_BYTES);
      2'd1:    n = 6'(SESS_BYTES);
      default: n = 6'(HDR_BYTES + NUM_DESC*DESC_BYTES);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/toc_const_div.sv
`timescale 1ns/1ps
module toc_const_div #(
  parameter int W       = 25,
  parameter int DIVISOR = 75,
  localparam int RW     = $clog2(DIVISOR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [W-1:0]  dividend_i,
  output logic          done_o,
  output logic [W-1:0]  quot_o,
  output logic [RW-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [RW:0] DIV_V = (RW+1)'(DIVISOR);

  logic [W-1:0]  sh_q, sh_n;
  logic [RW:0]   rem_q, rem_n, trial;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n, done_q, done_n;
  logic          ge, step_en;

  always_comb begin
    sh_n    = sh_q;
    rem_n   = rem_q;
    cnt_n   = cnt_q;
    busy_n  = busy_q;
    done_n  = 1'b0;
    trial   = {rem_q[RW-1:0], sh_q[W-1]};
    ge      = (trial >= DIV_V);
    step_en = go_i || busy_q;
    if (go_i) begin
      sh_n   = dividend_i;
      rem_n  = '0;
      cnt_n  = CW'(W);
      busy_n = 1'b1;
    end else if (busy_q) begin
      rem_n = ge ? (trial - DIV_V) : trial;
      sh_n  = {sh_q[W-2:0], ge};
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      if (step_en) begin
        sh_q  <= sh_n;
        rem_q <= rem_n;
        cnt_q <= cnt_n;
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = sh_q;
  assign rem_o  = rem_q[RW-1:0];

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q < DIV_V); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R2

endmodule

// File: rtl/toc_msf_conv.sv
`timescale 1ns/1ps
module toc_msf_conv import toc_pkg::*; #(
  parameter int SECW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic [SECW-1:0] lba_i,
  output logic            done_o,
  output logic [7:0]      min_o,
  output logic [7:0]      sec_o,
  output logic [7:0]      frm_o
);
  localparam int W   = SECW + 1;
  localparam int FRW = $clog2(FRM_PER_SEC);
  localparam int SRW = $clog2(SEC_PER_MIN);

  logic [W-1:0]   total, q_frames, q_mins;
  logic [FRW-1:0] r_frm;
  logic [SRW-1:0] r_sec;
  logic           d1_done, d2_done;

  assign total = W'(lba_i) + W'(LEADIN_FRAMES);

  toc_const_div #(.W(W), .DIVISOR(FRM_PER_SEC)) u_div_frm (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .dividend_i(total),
    .done_o(d1_done), .quot_o(q_frames), .rem_o(r_frm)
  );

  toc_const_div #(.W(W), .DIVISOR(SEC_PER_MIN)) u_div_sec (
    .clk(clk), .rst_n(rst_n), .go_i(d1_done), .dividend_i(q_frames),
    .done_o(d2_done), .quot_o(q_mins), .rem_o(r_sec)
  );

  assign done_o = d2_done;
  assign frm_o  = 8'(r_frm);
  assign sec_o  = 8'(r_sec);
  assign min_o  = (|q_mins[W-1:8]) ? 8'hFF : q_mins[7:0];

  AST_MSF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sec_o < 8'(SEC_PER_MIN)) && (frm_o < 8'(FRM_PER_SEC))); // R2

endmodule

// File: rtl/toc_byte_map.sv
`timescale 1ns/1ps
module toc_byte_map import toc_pkg::*; #(
  parameter int SECW = 24
) (
  input  logic [1:0]      fmt_i,
  input  logic            msf_i,
  input  logic            with_trk_i,
  input  logic [5:0]      idx_i,
  input  logic [SECW-1:0] sectors_i,
  input  logic [7:0]      min_i,
  input  logic [7:0]      sec_i,
  input  logic [7:0]      frm_i,
  output logic [7:0]      data_o
);
  logic [31:0] n32;
  logic [7:0]  addr_n [4];
  logic [7:0]  addr_z [4];
  logic [5:0]  len, hdr, j, base, o;
  logic [2:0]  e;
  logic        lout;
  logic [1:0]  d, k2;
  logic [7:0]  point;

  assign n32 = 32'(sectors_i);

  always_comb begin
    addr_n[0] = 8'h00;
    addr_n[1] = msf_i ? min_i : n32[23:16];
    addr_n[2] = msf_i ? sec_i : n32[15:8];
    addr_n[3] = msf_i ? frm_i : n32[7:0];
    if (!msf_i) addr_n[0] = n32[31:24];
    addr_z[0] = 8'h00;
    addr_z[1] = msf_i ? ZERO_MIN : 8'h00;
    addr_z[2] = msf_i ? ZERO_SEC : 8'h00;
    addr_z[3] = msf_i ? ZERO_FRM : 8'h00;
  end

  always_comb begin
    len  = resp_len(fmt_i, with_trk_i);
    hdr  = len - 6'd2;
    // basic listing: shift so the lead-out entry always sits at 12..19
    j    = with_trk_i ? idx_i : (idx_i + 6'(ENTRY_BYTES));
    e    = j[2:0] - 3'd4;
    lout = (j >= 6'(HDR_BYTES + ENTRY_BYTES));
    // raw listing: record number and offset inside it
    if (idx_i < 6'(HDR_BYTES + DESC_BYTES))        d = 2'd0;
    else if (idx_i < 6'(HDR_BYTES + 2*DESC_BYTES)) d = 2'd1;
    else if (idx_i < 6'(HDR_BYTES + 3*DESC_BYTES)) d = 2'd2;
    else                                           d = 2'd3;
    base = 6'(HDR_BYTES) + 6'(DESC_BYTES) * 6'(d);
    o    = idx_i - base;
    k2   = o[1:0] + 2'd1;
    case (d)
      2'd0:    point = PT_FIRST;
      2'd1:    point = PT_LAST;
      2'd2:    point = PT_LOUT;
      default: point = PT_TRK1;
    endcase

    data_o = 8'h00;
    if (idx_i == 6'd0)      data_o = 8'h00;
    else if (idx_i == 6'd1) data_o = {2'b00, hdr};
    else if (idx_i < 6'(HDR_BYTES)) data_o = 8'h01;
    else begin
      case (fmt_i)
        2'd0: begin
          if (!e[2]) begin
            case (e[1:0])
              2'd1:    data_o = lout ? CTRL_LOUT : CTRL_DATA;
              2'd2:    data_o = lout ? TRK_LOUT : 8'h01;
              default: data_o = 8'h00;
            endcase
          end else begin
            data_o = lout ? addr_n[e[1:0]] : addr_z[e[1:0]];
          end
        end
        2'd1: data_o = 8'h00;
        default: begin
          if (o == 6'd0)      data_o = 8'h01;
          else if (o == 6'd1) data_o = CTRL_DATA;
          else if (o == 6'd3) data_o = point;
          else if (o < 6'd7)  data_o = 8'h00;
          else begin
            case (d)
              2'd0, 2'd1: data_o = (k2 == 2'd1) ? 8'h01 : 8'h00;
              2'd2:       data_o = addr_n[k2];
              default:    data_o = addr_z[k2];
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/toc_resp_gen.sv
`timescale 1ns/1ps
module toc_resp_gen import toc_pkg::*; #(
  parameter int SECW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [SECW-1:0] sectors_i,
  input  logic            msf_i,
  input  logic [3:0]      fmt_i,
  input  logic [7:0]      trk_i,
  output logic [7:0]      data_o,
  output logic            valid_o,
  output logic            last_o,
  output logic            err_o
);
  gen_state_e      state_q, state_n;
  logic [5:0]      idx_q, idx_n, len_q;
  logic [1:0]      fmt_q, fmt_n;
  logic            msf_q, msf_n, trk_q, trk_n, err_q, err_n;
  logic [SECW-1:0] sec_q, sec_n;
  logic            accept, bad_req, need_conv, conv_go, conv_done, cap_en;
  logic [7:0]      m_b, s_b, f_b;

  always_comb begin
    accept    = (state_q == ST_IDLE) && start_i;
    bad_req   = (fmt_i > 4'd2) ||
                ((fmt_i == 4'd0) && (trk_i > 8'd1) && (trk_i != TRK_LOUT));
    need_conv = msf_i && (fmt_i != 4'd1);
    conv_go   = accept && !bad_req && need_conv;
    cap_en    = accept && !bad_req;
    len_q     = resp_len(fmt_q, trk_q);

    state_n = state_q;
    idx_n   = idx_q;
    fmt_n   = fmt_q;
    msf_n   = msf_q;
    trk_n   = trk_q;
    sec_n   = sec_q;
    err_n   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (bad_req) begin
            err_n = 1'b1;
          end else begin
            fmt_n   = fmt_i[1:0];
            msf_n   = msf_i;
            trk_n   = (trk_i <= 8'd1);
            sec_n   = sectors_i;
            idx_n   = '0;
            state_n = need_conv ? ST_CONV : ST_SEND;
          end
        end
      end
      ST_CONV: begin
        if (conv_done) state_n = ST_SEND;
      end
      ST_SEND: begin
        if (idx_q == len_q - 6'd1) state_n = ST_IDLE;
        else                       idx_n   = idx_q + 6'd1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      fmt_q   <= '0;
      msf_q   <= 1'b0;
      trk_q   <= 1'b0;
      sec_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      err_q   <= err_n;
      if (cap_en) begin
        fmt_q <= fmt_n;
        msf_q <= msf_n;
        trk_q <= trk_n;
        sec_q <= sec_n;
      end
    end
  end

  toc_msf_conv #(.SECW(SECW)) u_conv (
    .clk(clk), .rst_n(rst_n), .go_i(conv_go), .lba_i(sectors_i),
    .done_o(conv_done), .min_o(m_b), .sec_o(s_b), .frm_o(f_b)
  );

  toc_byte_map #(.SECW(SECW)) u_map (
    .fmt_i(fmt_q), .msf_i(msf_q), .with_trk_i(trk_q), .idx_i(idx_q),
    .sectors_i(sec_q), .min_i(m_b), .sec_i(s_b), .frm_i(f_b), .data_o(data_o)
  );

  assign valid_o = (state_q == ST_SEND);
  assign last_o  = valid_o && (idx_q == len_q - 6'd1);
  assign err_o   = err_q;

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o); // R13
  AST_STREAM_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> valid_o); // R10
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> (idx_q == $past(idx_q) + 6'd1)); // R10
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !valid_o); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(fmt_q) && $stable(msf_q) && $stable(sec_q))); // R12

endmodule

// File: tb/toc_resp_gen_tb_top.sv
`timescale 1ns/1ps
module toc_resp_gen_tb_top;
  localparam int SECW = 24;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i;
  logic [SECW-1:0] sectors_i;
  logic            msf_i;
  logic [3:0]      fmt_i;
  logic [7:0]      trk_i;
  logic [7:0]      data_o;
  logic            valid_o, last_o, err_o;

  int total = 0;
  int bad   = 0;
  int exp_b [64];
  int exp_len;
  bit exp_err;

  always #2.5 clk = ~clk;

  toc_resp_gen #(.SECW(SECW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sectors_i(sectors_i),
    .msf_i(msf_i), .fmt_i(fmt_i), .trk_i(trk_i), .data_o(data_o),
    .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", rq, act, ex, $time);
    end
  endtask

  task automatic push(input int b);
    exp_b[exp_len] = b & 255;
    exp_len++;
  endtask

  task automatic push_addr(input bit msf, input int n);
    int t;
    int m;
    t = n + 150;
    if (msf) begin
      m = t / 4500;
      if (m > 255) m = 255;
      push(0); push(m); push((t / 75) % 60); push(t % 75);
    end else begin
      push(n >> 24); push(n >> 16); push(n >> 8); push(n);
    end
  endtask

  task automatic build_exp(input int f, input bit msf, input int trk, input int n);
    exp_len = 0;
    exp_err = 0;
    if (f > 2 || (f == 0 && trk > 1 && trk != 170)) begin
      exp_err = 1;
      return;
    end
    push(0); push(0); push(1); push(1);
    if (f == 0) begin
      if (trk <= 1) begin
        push(0); push(8'h14); push(1); push(0); push_addr(msf, 0);
      end
      push(0); push(8'h16); push(8'hAA); push(0); push_addr(msf, n);
    end else if (f == 1) begin
      for (int i = 0; i < 8; i++) push(0);
    end else begin
      for (int d = 0; d < 4; d++) begin
        push(1); push(8'h14); push(0);
        push(d == 0 ? 8'hA0 : d == 1 ? 8'hA1 : d == 2 ? 8'hA2 : 8'h01);
        push(0); push(0); push(0);
        if (d < 2) begin push(0); push(1); push(0); push(0); end
        else if (d == 2) push_addr(msf, n);
        else push_addr(msf, 0);
      end
    end
    exp_b[1] = exp_len - 2;
  endtask

  function automatic string tag_for(input int f, input int i, input int trk, input bit msf);
    if (i < 4) return "R3";
    if (f == 1) return "R7";
    if (f == 2) return "R8";
    if (trk <= 1 && i < 12) return "R4";
    if (msf && i >= exp_len - 3) return "R2";
    return "R5";
  endfunction

  task automatic run_case(input int f, input bit msf, input int trk, input int n);
    int waited;
    build_exp(f, msf, trk, n);
    @(negedge clk);
    fmt_i = 4'(f); msf_i = msf; trk_i = 8'(trk); sectors_i = SECW'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    sectors_i = SECW'(n) ^ 24'h5A5A5A; msf_i = ~msf; trk_i = ~8'(trk);
    if (exp_err) begin
      chk(err_o == 1'b1, (f > 2) ? "R9" : "R6", int'(err_o), 1);
      chk(valid_o == 1'b0, "R13", int'(valid_o), 0);
      @(negedge clk);
      chk(err_o == 1'b0, "R13", int'(err_o), 0);
      for (int i = 0; i < 3; i++) begin
        chk(valid_o == 1'b0, "R13", int'(valid_o), 0);
        @(negedge clk);
      end
      return;
    end
    chk(err_o == 1'b0, "R13", int'(err_o), 0);
    if (!msf || f == 1) chk(valid_o == 1'b1, "R11", int'(valid_o), 1);
    else                chk(valid_o == 1'b0, "R11", int'(valid_o), 0);
    waited = 0;
    while (!valid_o && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    for (int i = 0; i < exp_len; i++) begin
      chk(valid_o == 1'b1, "R10", int'(valid_o), 1);
      chk(int'(data_o) == exp_b[i], tag_for(f, i, trk, msf), int'(data_o), exp_b[i]);
      chk(last_o == (i == exp_len - 1), "R10", int'(last_o), int'(i == exp_len - 1));
      @(negedge clk);
    end
    chk(valid_o == 1'b0, "R10", int'(valid_o), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R10 watchdog expired: got 0 expected 1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fl [6];
    int tl [6];
    int nl [7];
    fl = '{0, 1, 2, 3, 7, 15};
    tl = '{0, 1, 2, 170, 169, 255};
    nl = '{0, 1, 74, 75, 4349, 4350, 16777215};
    rst_n = 1'b0; start_i = 1'b0; sectors_i = '0; msf_i = 1'b0; fmt_i = '0; trk_i = '0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && last_o == 1'b0 && err_o == 1'b0, "R1", int'(valid_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(valid_o == 1'b0 && last_o == 1'b0 && err_o == 1'b0, "R1",
        int'({valid_o, last_o, err_o}), 0);

    foreach (fl[a]) foreach (tl[b]) foreach (nl[c])
      for (int m = 0; m < 2; m++)
        run_case(fl[a], m[0], tl[b], nl[c]);

    // R12: a start raised mid-reply must not disturb it
    build_exp(2, 0, 0, 1000);
    @(negedge clk);
    fmt_i = 4'd2; msf_i = 1'b0; trk_i = 8'd0; sectors_i = 24'd1000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < exp_len; i++) begin
      if (i == 10) begin start_i = 1'b1; fmt_i = 4'd3; sectors_i = 24'd7; end
      if (i == 11) start_i = 1'b0;
      chk(valid_o == 1'b1 && err_o == 1'b0, "R12", int'(valid_o), 1);
      chk(int'(data_o) == exp_b[i], "R12", int'(data_o), exp_b[i]);
      @(negedge clk);
    end
    for (int i = 0; i < 3; i++) begin
      chk(valid_o == 1'b0 && err_o == 1'b0, "R12", int'(valid_o), 0);
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule